// File: doc/BRIEF.md
# Condition Field Nibble Packer

The block walks over a run of 4-bit condition fields, turns each into a 4-bit result and stores those results as nibbles inside 64-bit integer registers. A result is the bitwise match of the field against a 4-bit pattern, filtered by a 4-bit care mask. A result bit is 1 when the care bit is set and the field bit equals the pattern bit. A single `start` pulse loads the whole job: the element count, the field base, the destination register base and the mode bits. The block then handles one element per clock.

Each element reads the condition-field port. It then reads the destination register through the integer port, replaces one nibble, and writes the register back in the same cycle. The source can step through consecutive fields or reuse a single field for every element. A vector destination spreads nibbles across consecutive registers, and a 2-bit width code sets how many nibbles fit in each register. A scalar destination packs every nibble into one register. Without chaining, a scalar destination stops after the first element. `done` pulses once the job ends, and `err` flags a job that a scalar destination cannot hold.

Top module: `crf_nibble_packer`

## Requirements
- R1: The nibble written for an element equals (NOT pattern XOR field) AND care, bitwise over 4 bits.
- R2: With `src_step` = 1, element i reads field (fld_base + i) modulo NFIELD. With `src_step` = 0, every element reads field `fld_base`.
- R3: With `dst_vector` = 1, the nibbles per register are set by `ew_code`: 00 gives 16, 01 gives 2, 10 gives 4 and 11 gives 8. Element i goes to register (dst_base + i / per) modulo NREG, at LSB-0 bits 4*b+3 down to 4*b, where b = i mod per.
- R4: With `dst_vector` = 0, every element goes to register `dst_base`, and element i occupies LSB-0 bits 4*i+3 down to 4*i. `ew_code` has no effect in this case.
- R5: Every bit of a written register outside the target nibble keeps its previous value. No register outside the addressed set is written.
- R6: With `dst_vector` = 0 and `chain_mode` = 0, only element 0 is processed, whatever the element count.
- R7: A job of N elements raises `busy` for exactly N cycles, starting in the cycle after `start`, with one register write in each of those cycles. `done` is high for one cycle, in the cycle after the last write.
- R8: With `dst_vector` = 0 and an element count above 16, no register is written. `err` and `done` are both high for one cycle, in the cycle after `start`.
- R9: An element count of 0 writes nothing. `done` pulses in the cycle after `start`, and `err` stays low.
- R10: A `start` pulse while `busy` is high is ignored. The running job completes with its own settings.
- R11: After reset, `busy`, `done`, `err` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads a job when the block is idle |
| elem_count | input | 7 | Number of elements, 0 to VL_MAX |
| src_step | input | 1 | 1: field address advances per element |
| dst_vector | input | 1 | 1: results spread over consecutive registers |
| chain_mode | input | 1 | 1: a scalar destination continues past element 0 |
| ew_code | input | 2 | Destination width code (00=64, 01=8, 10=16, 11=32 bits) |
| fld_base | input | 6 | First condition field index |
| dst_base | input | 5 | First destination register index |
| care | input | 4 | Care mask applied to each result |
| pattern | input | 4 | Pattern compared with each field |
| cr_addr | output | 6 | Condition field read address |
| cr_data | input | 4 | Condition field read data (same cycle) |
| reg_addr | output | 5 | Integer register address for read and write |
| reg_rdata | input | 64 | Integer register read data (same cycle) |
| reg_we | output | 1 | Integer register write enable |
| reg_wdata | output | 64 | Integer register write data |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Scalar destination overflow flag, paired with done |

## Verification
The block holds an element index and a set of latched settings. A corrupted index or a wrong register/offset split shows up as a nibble in the wrong place or in the wrong register. The write on that same cycle has the fault, so comparing the full register file after each job finds it. A wrong stop decision changes the number of `busy` cycles and writes. This can be seen when `done` arrives, and a faulty merge mask damages neighbouring bits on the first write. A job spans at most 64 cycles, so every internal fault reaches the ports within that window.

// File: rtl/crf_nibble_packer.sv
module crf_nibble_packer #(
  parameter int NFIELD = 64,
  parameter int NREG   = 32,
  parameter int VL_MAX = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [6:0]  elem_count,
  input  logic        src_step,
  input  logic        dst_vector,
  input  logic        chain_mode,
  input  logic [1:0]  ew_code,
  input  logic [5:0]  fld_base,
  input  logic [4:0]  dst_base,
  input  logic [3:0]  care,
  input  logic [3:0]  pattern,
  output logic [5:0]  cr_addr,
  input  logic [3:0]  cr_data,
  output logic [4:0]  reg_addr,
  input  logic [63:0] reg_rdata,
  output logic        reg_we,
  output logic [63:0] reg_wdata,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int FW = $clog2(NFIELD);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(VL_MAX + 1);
  localparam int SCALAR_MAX = 16;

  logic [CW-1:0] cnt_q, idx_q;
  logic [FW-1:0] fld_q;
  logic [RW-1:0] dst_q;
  logic [3:0]    care_q, pat_q;
  logic [1:0]    ew_q;
  logic          step_q, vec_q, chain_q;
  logic          busy_q, done_q, err_q;

  logic          accept, bad_len, last;
  logic [1:0]    lg;
  logic [CW-1:0] reg_off;
  logic [3:0]    slot;
  logic [5:0]    shamt;
  logic [3:0]    nib;

  assign accept  = start && !busy_q;
  assign bad_len = !dst_vector && (CW'(elem_count) > CW'(SCALAR_MAX));
  assign last    = (idx_q == cnt_q - CW'(1)) || (!vec_q && !chain_q);

  always_comb begin
    case (ew_q)
      2'b01:   lg = 2'd1;
      2'b10:   lg = 2'd2;
      2'b11:   lg = 2'd3;
      default: lg = 2'd0;
    endcase
  end

  assign reg_off = vec_q ? (idx_q >> ((lg == 2'd0) ? 3'd4 : {1'b0, lg})) : '0;
  assign slot    = vec_q ? (idx_q[3:0] & ((lg == 2'd0) ? 4'hF : ((4'd1 << lg) - 4'd1)))
                         : idx_q[3:0];
  assign shamt   = {slot, 2'b00};
  assign nib     = (~pat_q ^ cr_data) & care_q;

  assign cr_addr   = step_q ? (fld_q + FW'(idx_q)) : fld_q;
  assign reg_addr  = dst_q + RW'(reg_off);
  assign reg_we    = busy_q;
  assign reg_wdata = (reg_rdata & ~(64'hF << shamt)) | ({60'd0, nib} << shamt);
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      fld_q  <= '0;
      dst_q  <= '0;
      care_q <= '0;
      pat_q  <= '0;
      ew_q   <= '0;
      step_q <= 1'b0;
      vec_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad_len || elem_count == 7'd0) begin
          done_q <= 1'b1;
          err_q  <= bad_len;
        end else begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          cnt_q   <= CW'(elem_count);
          fld_q   <= FW'(fld_base);
          dst_q   <= RW'(dst_base);
          care_q  <= care;
          pat_q   <= pattern;
          ew_q    <= ew_code;
          step_q  <= src_step;
          vec_q   <= dst_vector;
          chain_q <= chain_mode;
        end
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/crf_nibble_packer_chk.sv
module crf_nibble_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [63:0] reg_rdata,
  input logic [63:0] reg_wdata,
  input logic [5:0]  cr_addr,
  input logic        step_q,
  input logic        vec_q,
  input logic [4:0]  dst_q
);
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> busy); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> (done && !busy)); // R8
  AST_ONE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($countones(reg_wdata ^ reg_rdata) <= 4)); // R5
  AST_FIXED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !step_q) |-> $stable(cr_addr)); // R2
  AST_SCALAR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !vec_q) |-> (reg_addr == dst_q)); // R4
endmodule

bind crf_nibble_packer crf_nibble_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .reg_wdata(reg_wdata), .cr_addr(cr_addr), .step_q(step_q),
  .vec_q(vec_q), .dst_q(dst_q)
);

// File: tb/sim_crf_nibble_packer.sv
`timescale 1ns/1ps
module sim_crf_nibble_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  elem_count = '0;
  logic        src_step = 1'b0, dst_vector = 1'b0, chain_mode = 1'b0;
  logic [1:0]  ew_code = '0;
  logic [5:0]  fld_base = '0;
  logic [4:0]  dst_base = '0;
  logic [3:0]  care = '0, pattern = '0;
  logic [5:0]  cr_addr;
  logic [3:0]  cr_data;
  logic [4:0]  reg_addr;
  logic [63:0] reg_rdata, reg_wdata;
  logic        reg_we, busy, done, err;

  logic [3:0]  cr_mem  [64];
  logic [63:0] reg_mem [32];
  logic [63:0] exp_mem [32];
  int vectors = 0, miscompares = 0, wr_cnt = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  crf_nibble_packer u0 (.*);

  assign cr_data   = cr_mem[cr_addr];
  assign reg_rdata = reg_mem[reg_addr];

  always @(posedge clk) if (reg_we) begin
    reg_mem[reg_addr] <= reg_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic fill();
    for (int k = 0; k < 64; k++) begin seed = nxt(seed); cr_mem[k] = seed[19:16]; end
    for (int k = 0; k < 32; k++) begin
      seed = nxt(seed); reg_mem[k][63:32] = seed;
      seed = nxt(seed); reg_mem[k][31:0]  = seed;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input int n, input bit sv, input bit dv,
                        input bit mr, input logic [1:0] ew, input int fb, input int db,
                        input logic [3:0] cm, input logic [3:0] pt, input bit poke);
    int nexp, lg, per, ri, b, bcnt, wait_c;
    logic [3:0] f, nb;
    bit eexp, seen_err;
    fill();
    for (int k = 0; k < 32; k++) exp_mem[k] = reg_mem[k];
    eexp = !dv && n > 16;
    nexp = (n == 0 || eexp) ? 0 : (!dv && !mr) ? 1 : n;
    lg = (ew == 2'b01) ? 1 : (ew == 2'b10) ? 2 : (ew == 2'b11) ? 3 : 4;
    per = 1 << lg;
    for (int i = 0; i < nexp; i++) begin
      f  = sv ? cr_mem[(fb + i) % 64] : cr_mem[fb];
      nb = (~pt ^ f) & cm;
      ri = dv ? (db + i / per) % 32 : db;
      b  = dv ? i % per : i;
      exp_mem[ri][4*b +: 4] = nb;
    end
    @(negedge clk);
    elem_count = 7'(n); src_step = sv; dst_vector = dv; chain_mode = mr;
    ew_code = ew; fld_base = 6'(fb); dst_base = 5'(db); care = cm; pattern = pt;
    wr_cnt = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bcnt = 0; wait_c = 0; seen_err = 0;
    while (!done && wait_c < 200) begin
      if (busy) bcnt++;
      if (poke && bcnt == 2) begin
        elem_count = 7'd1; dst_vector = 1'b0; dst_base = 5'(db + 7); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      wait_c++;
    end
    start = 1'b0;
    if (wait_c >= 200) chk(0, req, "watchdog: done never seen", 0, 1);
    seen_err = err;
    chk(bcnt == nexp, "R7", {req, " busy cycles"}, 64'(bcnt), 64'(nexp));
    chk(wr_cnt == nexp, "R7", {req, " write count"}, 64'(wr_cnt), 64'(nexp));
    chk(seen_err == eexp, "R8", {req, " err with done"}, 64'(seen_err), 64'(eexp));
    for (int k = 0; k < 32; k++)
      chk(reg_mem[k] == exp_mem[k], req, $sformatf("reg %0d", k), reg_mem[k], exp_mem[k]);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !reg_we, "R11", "outputs after reset",
        {60'd0, busy, done, err, reg_we}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op("R1 R3 ew00",        10, 1, 1, 0, 2'b00, 3, 4, 4'hF, 4'h5, 0);
    run_op("R1 R3 ew01",        10, 1, 1, 0, 2'b01, 0, 2, 4'hB, 4'h3, 0);
    run_op("R3 ew10",           13, 1, 1, 1, 2'b10, 20, 9, 4'h7, 4'hC, 0);
    run_op("R3 ew11",           20, 1, 1, 0, 2'b11, 40, 30, 4'hE, 4'h9, 0);
    run_op("R3 full span",      64, 1, 1, 0, 2'b01, 0, 0, 4'hF, 4'h0, 0);
    run_op("R2 fixed source",    9, 0, 1, 0, 2'b10, 17, 5, 4'hF, 4'hA, 0);
    run_op("R2 field wrap",      6, 1, 1, 0, 2'b00, 61, 31, 4'hD, 4'h6, 0);
    run_op("R4 scalar chain",   16, 1, 0, 1, 2'b01, 8, 11, 4'hF, 4'h1, 0);
    run_op("R6 scalar no chain",12, 1, 0, 0, 2'b11, 8, 12, 4'hF, 4'h2, 0);
    run_op("R8 scalar overflow",17, 1, 0, 1, 2'b00, 0, 3, 4'hF, 4'h4, 0);
    run_op("R9 zero count",      0, 1, 1, 0, 2'b00, 0, 3, 4'hF, 4'h4, 0);
    run_op("R5 care zero",       5, 1, 1, 0, 2'b00, 10, 14, 4'h0, 4'hF, 0);
    run_op("R10 start ignored",  8, 1, 1, 0, 2'b01, 30, 16, 4'hF, 4'h8, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule